// File: doc/BRIEF.md
# Asynchronous Receive Packet FIFO

This block buffers asynchronous serial-bus packets as they arrive from a link receiver and lets a host drain them through an 8-bit register port. Each packet arrives as a run of 32-bit data quadlets. A separate end-of-packet strobe follows, carrying the acknowledge code that was sent and two error indications: a data CRC error and a length mismatch. On that strobe the block stores one extra trailer quadlet. The trailer holds a 4-bit completion code in its least significant bits, so the host always learns how each packet ended, including packets for which no acknowledge went out on the bus.

The host sees the head quadlet as four byte addresses, most significant byte first, plus one status byte. The status byte reports empty, exactly-one-left, at-least-four-available, and a data-complete marker. The marker tells the host that the quadlet it has just taken closed a packet. While the at-least-four bit is high, the host can read four whole quadlets without polling status in between. When the bit is low, it polls status after every quadlet. If storage runs out during a packet, the remaining data of that packet is thrown away. One slot is kept free so that the trailer can still mark the loss.

Top module: `async_rx_fifo`

## Requirements
- R1: After a synchronous reset the FIFO holds nothing, and the status byte (address 4) reads 0x01: empty set, all other flags clear.
- R2: Stored quadlets, data and trailers alike, are read back in the order they were written.
- R3: Addresses 0, 1, 2 and 3 return bits 31:24, 23:16, 15:8 and 7:0 of the head quadlet. Data addresses return 0x00 while the FIFO is empty, and addresses 5 to 7 always return 0x00.
- R4: Only a read of address 3 on a non-empty FIFO removes a quadlet. Reads of addresses 0 to 2, reads of the status byte, and a read of address 3 while empty change neither the contents nor any flag.
- R5: Status bit 0 (empty) is 1 exactly when no quadlet is stored.
- R6: Status bit 1 (almost empty) is 1 exactly when one quadlet is stored.
- R7: Status bit 2 (four available) is 1 exactly when four or more quadlets are stored.
- R8: Status bit 3 (data complete) is set when the quadlet removed was a trailer and cleared when it was a data quadlet. It holds its value between removals and is 0 after reset.
- R9: Each end-of-packet strobe stores a trailer quadlet {28'h0, code}. For a clean packet the code is the supplied acknowledge code, and this also holds for packets with no data quadlets.
- R10: If no overflow occurred, a CRC error or a length mismatch makes the trailer code 0xD.
- R11: A data quadlet that arrives while DEPTH-1 or more quadlets are stored is dropped. So is every later data quadlet of the same packet. That packet's trailer code is then 0x4, which takes priority over 0xD. The space test uses the occupancy before any pop in the same cycle.
- R12: A trailer is dropped only when all DEPTH entries are full at the end-of-packet strobe.
- R13: The status flags are registered and reflect a push or pop in the cycle after it.
- R14: A data strobe in the same cycle as an end-of-packet strobe is discarded. Only the trailer is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Data quadlet strobe from the receiver |
| inData | input | 32 | Data quadlet |
| pktEnd | input | 1 | End-of-packet strobe; writes the trailer |
| crcErr | input | 1 | Data CRC error flag, sampled with pktEnd |
| lenErr | input | 1 | Length mismatch flag, sampled with pktEnd |
| ackCode | input | 4 | Acknowledge code sent, sampled with pktEnd |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | 3 | Host byte address: 0-3 head quadlet, 4 status |
| rdData | output | 8 | Selected byte, combinational from rdAddr and stored state |

## Verification
The bench pushes the overflow boundary so that the DEPTH-1 reservation is exercised. A design that sized the space test on the full depth would store a sixteenth data quadlet and then lose the trailer. It fills the FIFO completely with a trailer and sends a second end-of-packet strobe. A block that wrapped its pointers would then overwrite the head instead of dropping the trailer. Repeated partial-byte reads and reads of address 3 while empty show whether pops fire on the wrong byte. A collision of data and end-of-packet strobes, together with random mixed push and pop traffic, catches flags decoded off by one in occupancy, a data-complete marker updated on the wrong quadlet, and a bad-data code that wins over the overflow code.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;
  localparam int STAT_W = 4;

  // status byte bit positions (host software decodes these)
  localparam int ST_EMPTY  = 0;
  localparam int ST_ALMOST = 1;
  localparam int ST_FOUR   = 2;
  localparam int ST_DC     = 3;

  localparam logic [2:0] ADDR_LSB    = 3'd3;
  localparam logic [2:0] ADDR_STATUS = 3'd4;

  localparam logic [CODE_W-1:0] CODE_OVERFLOW = 4'h4;
  localparam logic [CODE_W-1:0] CODE_BAD_DATA = 4'hD;

  typedef struct packed {
    logic pushData;
    logic pushTrailer;
    logic pop;
  } arxStrobe_t;

  typedef struct packed {
    logic              endMark;
    logic [WORD_W-1:0] word;
  } arxEntry_t;
endpackage

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              pktEnd,
  input  logic              crcErr,
  input  logic              lenErr,
  input  logic [CODE_W-1:0] ackCode,
  input  logic              rdEn,
  input  logic [2:0]        rdAddr,
  input  logic              headEnd,
  output arxStrobe_t        strobe,
  output logic [CODE_W-1:0] trailerCode,
  output logic [CNT_W-1:0]  count,
  output logic [STAT_W-1:0] status
);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] FOUR_C  = CNT_W'(4);

  logic             emptyQ, almostQ, fourQ, dcQ, ovfQ;
  logic             roomAny, roomData, dropData;
  logic [CNT_W-1:0] countNext;

  // space tests use occupancy at the start of the cycle
  always_comb begin
    roomAny            = count < FULL_C;
    roomData           = count < LIMIT_C;
    strobe.pop         = rdEn && (rdAddr == ADDR_LSB) && (count != '0);
    strobe.pushTrailer = pktEnd && roomAny;
    strobe.pushData    = inValid && !pktEnd && !ovfQ && roomData;
    dropData           = inValid && !pktEnd && !strobe.pushData;
  end

  always_comb begin
    if (ovfQ)                  trailerCode = CODE_OVERFLOW;
    else if (crcErr || lenErr) trailerCode = CODE_BAD_DATA;
    else                       trailerCode = ackCode;
  end

  always_comb begin
    countNext = count;
    if (strobe.pushData || strobe.pushTrailer) countNext = countNext + ONE_C;
    if (strobe.pop)                            countNext = countNext - ONE_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      emptyQ  <= 1'b1;
      almostQ <= 1'b0;
      fourQ   <= 1'b0;
      dcQ     <= 1'b0;
      ovfQ    <= 1'b0;
    end else begin
      count   <= countNext;
      emptyQ  <= (countNext == '0);
      almostQ <= (countNext == ONE_C);
      fourQ   <= (countNext >= FOUR_C);
      if (strobe.pop) dcQ <= headEnd;
      if (pktEnd)        ovfQ <= 1'b0;
      else if (dropData) ovfQ <= 1'b1;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_EMPTY]  = emptyQ;
    status[ST_ALMOST] = almostQ;
    status[ST_FOUR]   = fourQ;
    status[ST_DC]     = dcQ;
  end
endmodule

// File: rtl/arx_datapath.sv
module arx_datapath
  import arx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  arxStrobe_t        strobe,
  input  logic [WORD_W-1:0] inData,
  input  logic [CODE_W-1:0] trailerCode,
  input  logic [2:0]        rdAddr,
  input  logic [STAT_W-1:0] status,
  output logic              headEnd,
  output logic [BYTE_W-1:0] rdData
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  arxEntry_t        mem [DEPTH];
  arxEntry_t        wrEntry, head;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [1:0]       laneIdx;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (strobe.pushTrailer) begin
      wrEntry.endMark = 1'b1;
      wrEntry.word    = {{(WORD_W - CODE_W){1'b0}}, trailerCode};
    end else begin
      wrEntry.endMark = 1'b0;
      wrEntry.word    = inData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushData || strobe.pushTrailer) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.pushData || strobe.pushTrailer) wrPtr <= bump(wrPtr);
      if (strobe.pop)                            rdPtr <= bump(rdPtr);
    end
  end

  assign head    = mem[rdPtr];
  assign headEnd = head.endMark;
  assign laneIdx = ~rdAddr[1:0];

  // address 0 is the most significant byte
  always_comb begin
    rdData = '0;
    if (!rdAddr[2]) begin
      if (!status[ST_EMPTY]) rdData = head.word[{laneIdx, 3'b000} +: BYTE_W];
    end else if (rdAddr == ADDR_STATUS) begin
      rdData = {{(BYTE_W - STAT_W){1'b0}}, status};
    end
  end
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
  import arx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] inData,
  input  logic        pktEnd,
  input  logic        crcErr,
  input  logic        lenErr,
  input  logic [3:0]  ackCode,
  input  logic        rdEn,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  arxStrobe_t        strobe;
  logic [CODE_W-1:0] trailerCode;
  logic [CNT_W-1:0]  count;
  logic [STAT_W-1:0] status;
  logic              headEnd;

  arx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .pktEnd(pktEnd),
    .crcErr(crcErr), .lenErr(lenErr), .ackCode(ackCode),
    .rdEn(rdEn), .rdAddr(rdAddr), .headEnd(headEnd),
    .strobe(strobe), .trailerCode(trailerCode), .count(count), .status(status)
  );

  arx_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .inData(inData),
    .trailerCode(trailerCode), .rdAddr(rdAddr), .status(status),
    .headEnd(headEnd), .rdData(rdData)
  );
endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             pktEnd,
  input logic             rdEn,
  input logic [2:0]       rdAddr,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       status,
  input logic             headEnd
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && status == 4'b0001)); // R1

  AST_NO_PARTIAL_POP: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr != 3'd3 && !inValid && !pktEnd) |=> $stable(count)); // R4

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == 3'd3 && count != '0 && !inValid && !pktEnd)
      |=> (count == $past(count) - 1'b1)); // R4

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
    status[0] == (count == '0)); // R5

  AST_ALMOST_FLAG: assert property (@(posedge clk) disable iff (rst)
    status[1] == (count == CNT_W'(1))); // R6

  AST_FOUR_FLAG: assert property (@(posedge clk) disable iff (rst)
    status[2] == (count >= CNT_W'(4))); // R7

  AST_DC_ON_TRAILER: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == 3'd3 && count != '0 && headEnd) |=> status[3]); // R8

  AST_DC_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == 3'd3 && count != '0 && !headEnd) |=> !status[3]); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R12
endmodule

bind async_rx_fifo arx_checker #(.DEPTH(DEPTH)) u_arxChecker (
  .clk(clk), .rst(rst), .inValid(inValid), .pktEnd(pktEnd),
  .rdEn(rdEn), .rdAddr(rdAddr), .count(count), .status(status),
  .headEnd(headEnd)
);

// File: tb/test_async_rx_fifo.sv
`timescale 1ns/1ps
module test_async_rx_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        pktEnd = 1'b0;
  logic        crcErr = 1'b0;
  logic        lenErr = 1'b0;
  logic [3:0]  ackCode = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = 3'd4;
  logic [7:0]  rdData;

  always #10 clk = ~clk;

  async_rx_fifo #(.DEPTH(DEPTH)) i_async_rx_fifo (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .pktEnd(pktEnd),
    .crcErr(crcErr), .lenErr(lenErr), .ackCode(ackCode),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  int         compared = 0;
  int         mismatched = 0;
  bit         finished = 0;
  string      scenTag = "R1";
  logic [32:0] mq[$];
  bit         mOvf = 0;
  bit         mDc = 0;
  logic [7:0] lastByte;

  function automatic logic [7:0] expByte(input logic [2:0] a);
    int n = mq.size();
    logic [32:0] h;
    if (a == 3'd4) return {4'b0, mDc, (n >= 4), (n == 1), (n == 0)};
    if (a[2] == 1'b0) begin
      if (n == 0) return 8'h00;
      h = mq[0];
      return h[31 - 8*int'(a[1:0]) -: 8];
    end
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic modelUpdate(input bit iv, input logic [31:0] d, input bit pe, input bit cr,
                             input bit le, input logic [3:0] ak, input bit re,
                             input logic [2:0] ra);
    int n = mq.size();
    logic [3:0] code;
    if (re && ra == 3'd3 && n != 0) begin
      mDc = mq[0][32];
      void'(mq.pop_front());
    end
    if (pe) begin
      if (n < DEPTH) begin
        code = mOvf ? 4'h4 : ((cr || le) ? 4'hD : ak);
        mq.push_back({1'b1, 28'h0, code});
      end
      mOvf = 0;
    end else if (iv) begin
      if (!mOvf && n < DEPTH - 1) mq.push_back({1'b0, d});
      else mOvf = 1;
    end
  endtask

  task automatic step(input bit iv, input logic [31:0] d, input bit pe, input bit cr,
                      input bit le, input logic [3:0] ak, input bit re, input logic [2:0] ra);
    @(negedge clk);
    inValid = iv; inData = d; pktEnd = pe; crcErr = cr; lenErr = le;
    ackCode = ak; rdEn = re; rdAddr = ra;
    #1;
    lastByte = rdData;
    check(scenTag, {24'h0, rdData}, {24'h0, expByte(ra)}, "per-cycle model byte");
    @(posedge clk);
    modelUpdate(iv, d, pe, cr, le, ak, re, ra);
  endtask

  task automatic sendData(input logic [31:0] d);
    step(1, d, 0, 0, 0, 4'h0, 0, 3'd4);
  endtask

  task automatic sendEnd(input bit cr, input bit le, input logic [3:0] ak);
    step(0, 32'h0, 1, cr, le, ak, 0, 3'd4);
  endtask

  task automatic readByte(input logic [2:0] a);
    step(0, 32'h0, 0, 0, 0, 4'h0, 1, a);
  endtask

  task automatic readQuad(output logic [31:0] q);
    q = '0;
    for (int i = 0; i < 4; i++) begin
      readByte(3'(i));
      q = {q[23:0], lastByte};
    end
  endtask

  task automatic readStatus(output logic [7:0] s);
    readByte(3'd4);
    s = lastByte;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R1 watchdog: got still running exp finished");
    finishRun();
  end

  initial begin
    logic [31:0] q;
    logic [7:0]  s;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: state after reset
    scenTag = "R1";
    readStatus(s);
    check("R1", {24'h0, s}, 32'h01, "status after reset");

    // R2 R3 R5 R6 R7 R8 R9: one clean packet of two quadlets
    scenTag = "R2";
    sendData(32'h11223344);
    sendData(32'hA5B6C7D8);
    sendEnd(0, 0, 4'h1);
    readStatus(s);
    check("R7", {24'h0, s}, 32'h00, "three stored: no four, no almost");
    scenTag = "R3";
    readQuad(q);
    check("R3", q, 32'h11223344, "first quadlet MSB first");

    // R4: partial-byte and status reads pop nothing
    scenTag = "R4";
    for (int k = 0; k < 3; k++) begin
      readByte(3'd0); readByte(3'd1); readByte(3'd2); readByte(3'd4);
    end
    readByte(3'd6);
    check("R3", {24'h0, lastByte}, 32'h0, "unused address reads zero");
    readStatus(s);
    check("R4", {24'h0, s}, 32'h00, "occupancy unchanged by non-pop reads");
    readQuad(q);
    check("R2", q, 32'hA5B6C7D8, "second quadlet in order");
    readStatus(s);
    check("R6", {24'h0, s}, 32'h02, "one left, dc clear after data");
    readQuad(q);
    check("R9", q, 32'h00000001, "trailer carries ack code");
    readStatus(s);
    check("R8", {24'h0, s}, 32'h09, "empty with dc after trailer");
    check("R5", {31'h0, s[0]}, 32'h1, "empty bit");

    // R4: pop of empty FIFO has no effect
    readByte(3'd3);
    readStatus(s);
    check("R4", {24'h0, s}, 32'h09, "pop on empty ignored");

    // R13: flags follow a push on the next cycle
    scenTag = "R13";
    sendData(32'h00000055);
    readStatus(s);
    check("R13", {24'h0, s}, 32'h0A, "almost set one cycle after push");
    readQuad(q);
    check("R8", {24'h0, q}, 32'h55, "data quadlet");
    readStatus(s);
    check("R8", {24'h0, s}, 32'h01, "dc cleared after data pop");

    // R10 R9: error codes, zero-length packet, four-available
    scenTag = "R10";
    sendData(32'hCAFE0001);
    sendEnd(1, 0, 4'h1);
    sendEnd(0, 1, 4'h2);
    sendEnd(0, 0, 4'h2);
    readStatus(s);
    check("R7", {24'h0, s}, 32'h04, "four available");
    readQuad(q);
    check("R2", q, 32'hCAFE0001, "data before trailer");
    readQuad(q);
    check("R10", q, 32'h0000000D, "crc error code");
    readQuad(q);
    check("R10", q, 32'h0000000D, "length mismatch code");
    readQuad(q);
    check("R9", q, 32'h00000002, "zero-length packet trailer");

    // R11: overflow drops the rest of the packet, code 0x4 beats 0xD
    scenTag = "R11";
    for (int i = 0; i < 20; i++) sendData(32'h1000 + 32'(i));
    sendEnd(1, 0, 4'h1);
    readStatus(s);
    check("R11", {28'h0, s[3:0] & 4'h7}, 32'h4, "full: four set");
    for (int i = 0; i < DEPTH - 1; i++) begin
      readQuad(q);
      check("R11", q, 32'h1000 + 32'(i), "kept data");
    end
    readQuad(q);
    check("R11", q, 32'h00000004, "overflow trailer");

    // R12: trailer dropped only when completely full
    scenTag = "R12";
    for (int i = 0; i < DEPTH - 1; i++) sendData(32'h2000 + 32'(i));
    sendEnd(0, 0, 4'h5);
    sendEnd(0, 0, 4'h6);
    for (int i = 0; i < DEPTH - 1; i++) readQuad(q);
    readQuad(q);
    check("R12", q, 32'h00000005, "trailer fitting in the last slot");
    readStatus(s);
    check("R12", {24'h0, s}, 32'h09, "second trailer was dropped");

    // R14: data strobe colliding with end-of-packet is discarded
    scenTag = "R14";
    step(1, 32'hDEADBEEF, 1, 0, 0, 4'h3, 0, 3'd4);
    readQuad(q);
    check("R14", q, 32'h00000003, "only trailer stored");
    readStatus(s);
    check("R14", {24'h0, s}, 32'h09, "nothing else stored");

    // R2 R4 R13: random mixed traffic against the model
    scenTag = "R2";
    for (int c = 0; c < 600; c++) begin
      step(($urandom % 3) == 0, $urandom, ($urandom % 9) == 0, ($urandom % 5) == 0,
           ($urandom % 7) == 0, 4'($urandom), ($urandom % 2) == 0, 3'($urandom % 8));
    end
    for (int c = 0; c < 4 * DEPTH && mq.size() != 0; c++) readByte(3'd3);
    readStatus(s);
    check("R5", {31'h0, s[0]}, 32'h1, "drained to empty");

    finishRun();
  end
endmodule